// File: doc/BRIEF.md
# Real-Time-Clock Timekeeping Core with Delayed Field Commit

The block keeps wall-clock time as four separate counters: seconds (6 bits), minutes (6 bits), hours (5 bits) and days (16 bits). A one-cycle `tickEn` pulse is the one-second time base and stands in for the slow crystal domain. Software reads the running counters through a small register port. To change the time it writes new values into separate staging registers. Each staged field waits a programmable number of clock cycles, which models the slow commit into an always-on domain. After that wait the field is loaded into its counter on the next tick, and a per-field raw status bit reports that the commit is done.

The raw status bits can be enabled, masked and cleared by writing ones, and an interrupt line is raised from the masked set. A power-status register starts with a power-loss signature. Software rewrites it through a power-control register to record that the time has been set and can be trusted.

Top module: `rtc_time_core`

## Requirements
- R1: After reset all four counters, the interrupt enable (0x30), raw status (0x34) and masked status (0x3C) read 0, the power status (0x5C) reads 0x0096, and `irq` is 0.
- R2: Each `tickEn` cycle advances the time by one second. Seconds roll over 59 to 0 and carry into minutes, minutes roll over 59 to 0 and carry into hours, hours roll over 23 to 0 and carry into days, and days wrap from 65535 to 0. Without a tick, the counters hold. The counters read at 0x00 (seconds), 0x04 (minutes), 0x08 (hours) and 0x0C (days).
- R3: Writing a staging register (0x10 seconds, 0x14 minutes, 0x18 hours, 0x1C days) leaves the running counter unchanged, and the staging register reads back the written value masked to the field width.
- R4: A staged field commits on the first tick that comes at least COMMIT_CYCLES clock cycles after its write. That tick loads the counter and sets raw status bit 8+f, where f is 0 for seconds, 1 for minutes, 2 for hours and 3 for days. A tick that comes earlier advances the time normally and sets no raw bit.
- R5: On a commit tick, a loaded field takes the staged value. Any carry coming into that field from below is ignored, and a rollover of the field's old value does not carry into the next field.
- R6: Writing a staging register again before its commit replaces the staged value and restarts the wait.
- R7: Writing 0x38 clears every raw status bit whose write-data bit is 1. A commit in the same cycle as a clear of its bit leaves the bit set.
- R8: The enable register at 0x30 holds data bits 15:0 for read and write. The masked status at 0x3C equals raw status AND enable. `irq` is 1 exactly when the masked status is non-zero.
- R9: A write to 0x58 clears each status bit in 7:0 whose data bit is 1 and replaces status bits 15:8 with data bits 15:8. Writing 0x00FF and then 0x6900 makes 0x5C read 0x6900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-second time-base pulse, one clock wide |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Read data for `regAddr`, combinational |
| irq | output | 1 | OR of the masked status bits |

## Verification
Two pairs of events can land in the same cycle. A commit tick can coincide with a carry out of the field below, and a commit can coincide with a write-one-to-clear of its own status bit. For the first, the bench parks the seconds at 59 and lets a staged minutes value or a staged seconds value commit on the tick that would roll over. It then judges the loaded value and the untouched neighbour field. For the second, the bench drives a tick together with a clear write in the cycle the seconds commit fires, and it expects raw bit 8 to stay set while the counter shows the staged value.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int DAY_W    = 16;
  localparam int N_FIELDS = 4;
  localparam int INT_W    = 16;
  localparam int UPD_BIT0 = 8;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  localparam int OFS_NOW0 = 'h00;
  localparam int OFS_UPD0 = 'h10;
  localparam int OFS_IEN  = 'h30;
  localparam int OFS_RAW  = 'h34;
  localparam int OFS_CLR  = 'h38;
  localparam int OFS_MSK  = 'h3C;
  localparam int OFS_PCTL = 'h58;
  localparam int OFS_PSTS = 'h5C;

  localparam logic [15:0] PWR_LOST = 16'h0096;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [DAY_W-1:0]  day;
  } timeVal_t;

  // field index: 0 seconds, 1 minutes, 2 hours, 3 days
  typedef struct packed {
    logic                tick;
    logic [N_FIELDS-1:0] load;
    timeVal_t            staged;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtc_time_datapath.sv
module rtc_time_datapath
  import rtc_time_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output timeVal_t    now
);
  timeVal_t nxt;
  logic carrySec, carryMin, carryHour;

  always_comb begin
    nxt       = now;
    carrySec  = 1'b0;
    carryMin  = 1'b0;
    carryHour = 1'b0;
    if (strobe.tick) begin
      // seconds: always advance unless loaded
      if (strobe.load[0]) begin
        nxt.sec = strobe.staged.sec;
      end else if (now.sec >= SEC_W'(SEC_LAST)) begin
        nxt.sec  = '0;
        carrySec = 1'b1;
      end else begin
        nxt.sec = now.sec + 1'b1;
      end
      // minutes
      if (strobe.load[1]) begin
        nxt.min = strobe.staged.min;
      end else if (carrySec) begin
        if (now.min >= MIN_W'(MIN_LAST)) begin
          nxt.min  = '0;
          carryMin = 1'b1;
        end else begin
          nxt.min = now.min + 1'b1;
        end
      end
      // hours
      if (strobe.load[2]) begin
        nxt.hour = strobe.staged.hour;
      end else if (carryMin) begin
        if (now.hour >= HOUR_W'(HOUR_LAST)) begin
          nxt.hour  = '0;
          carryHour = 1'b1;
        end else begin
          nxt.hour = now.hour + 1'b1;
        end
      end
      // days wrap at the field width
      if (strobe.load[3]) begin
        nxt.day = strobe.staged.day;
      end else if (carryHour) begin
        nxt.day = now.day + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) now <= '0;
    else       now <= nxt;
  end
endmodule

// File: rtl/rtc_time_ctrl.sv
module rtc_time_ctrl
  import rtc_time_pkg::*;
#(
  parameter int COMMIT_CYCLES = 1000,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  timeVal_t          now,
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

  logic [DAY_W-1:0]    stagedArr [N_FIELDS];
  logic [DAY_W-1:0]    nowArr    [N_FIELDS];
  logic [N_FIELDS-1:0] pend, wrHit, loadVec, rawUpd;
  logic [INT_W-1:0]    intEn, rawAll, maskedAll;
  logic [15:0]         pwrSts;
  logic                unusedHi;

  assign unusedHi = ^regWrData[DATA_W-1:INT_W];

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam int FW = (i == 3) ? DAY_W : (i == 2) ? HOUR_W : SEC_W;
    logic [CNT_W-1:0] waitCnt;

    assign wrHit[i]   = regWrEn && (regAddr == ADDR_W'(OFS_UPD0 + 4 * i));
    assign loadVec[i] = pend[i] && (waitCnt == '0) && tickEn && !wrHit[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[i]      <= 1'b0;
        waitCnt      <= '0;
        stagedArr[i] <= '0;
      end else if (wrHit[i]) begin
        pend[i]      <= 1'b1;
        waitCnt      <= CNT_W'(COMMIT_CYCLES);
        stagedArr[i] <= DAY_W'(regWrData[FW-1:0]);
      end else if (loadVec[i]) begin
        pend[i] <= 1'b0;
      end else if (pend[i] && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  assign nowArr[0] = DAY_W'(now.sec);
  assign nowArr[1] = DAY_W'(now.min);
  assign nowArr[2] = DAY_W'(now.hour);
  assign nowArr[3] = now.day;

  assign strobe.tick        = tickEn;
  assign strobe.load        = loadVec;
  assign strobe.staged.sec  = stagedArr[0][SEC_W-1:0];
  assign strobe.staged.min  = stagedArr[1][MIN_W-1:0];
  assign strobe.staged.hour = stagedArr[2][HOUR_W-1:0];
  assign strobe.staged.day  = stagedArr[3];

  // status and enable registers; a commit outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawUpd <= '0;
      intEn  <= '0;
      pwrSts <= PWR_LOST;
    end else begin
      if (regWrEn && regAddr == ADDR_W'(OFS_CLR))
        rawUpd <= (rawUpd & ~regWrData[UPD_BIT0 +: N_FIELDS]) | loadVec;
      else
        rawUpd <= rawUpd | loadVec;
      if (regWrEn && regAddr == ADDR_W'(OFS_IEN))
        intEn <= regWrData[INT_W-1:0];
      if (regWrEn && regAddr == ADDR_W'(OFS_PCTL))
        pwrSts <= {regWrData[15:8], pwrSts[7:0] & ~regWrData[7:0]};
    end
  end

  assign rawAll    = INT_W'(rawUpd) << UPD_BIT0;
  assign maskedAll = rawAll & intEn;
  assign irq       = |maskedAll;

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (regAddr == ADDR_W'(OFS_NOW0 + 4 * i)) regRdData = DATA_W'(nowArr[i]);
      if (regAddr == ADDR_W'(OFS_UPD0 + 4 * i)) regRdData = DATA_W'(stagedArr[i]);
    end
    if (regAddr == ADDR_W'(OFS_IEN))  regRdData = DATA_W'(intEn);
    if (regAddr == ADDR_W'(OFS_RAW))  regRdData = DATA_W'(rawAll);
    if (regAddr == ADDR_W'(OFS_MSK))  regRdData = DATA_W'(maskedAll);
    if (regAddr == ADDR_W'(OFS_PSTS)) regRdData = DATA_W'(pwrSts);
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_time_pkg::*;
#(
  parameter int COMMIT_CYCLES = 1000,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  timeVal_t    nowVal;
  ctrlStrobe_t strobe;

  rtc_time_ctrl #(
    .COMMIT_CYCLES(COMMIT_CYCLES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .tickEn(tickEn),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .regWrData(regWrData),
    .now(nowVal),
    .strobe(strobe),
    .regRdData(regRdData),
    .irq(irq)
  );

  rtc_time_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .now(nowVal)
  );
endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk
  import rtc_time_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              irq,
  input timeVal_t          now,
  input ctrlStrobe_t       strobe
);
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(now));

  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.load[0] && now.sec < SEC_W'(SEC_LAST))
      |=> now.sec == SEC_W'($past(now.sec) + 1'b1));

  a_r5_min_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[1] |=> now.min == $past(strobe.staged.min));

  a_r5_sec_load_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load[0] |=> now.sec == $past(strobe.staged.sec));

  a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(strobe.tick) || $past(regWrEn)));

  a_r8_irq_vs_masked: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_MSK)) |-> (irq == (regRdData != '0)));

  a_r9_pwr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_PSTS) && $past(regAddr) == ADDR_W'(OFS_PSTS) && !$past(regWrEn))
      |-> $stable(regRdData));
endmodule

bind rtc_time_core rtc_time_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .regRdData(regRdData),
  .irq(irq),
  .now(nowVal),
  .strobe(strobe)
);

// File: tb/rtc_time_core_tb.sv
module rtc_time_core_tb;
  localparam int CMT = 20;
  localparam int SETTLE = CMT + 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int nCmp = 0;
  int nBad = 0;
  logic rdReq = 1'b0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  rtc_time_core #(.COMMIT_CYCLES(CMT)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  // monitor: pops the expected item for each read request
  always @(negedge clk) begin
    if (rdReq && expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      nCmp++;
      if (regRdData !== e) begin
        nBad++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", t, regAddr, regRdData, e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    regAddr = a; rdReq = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); #1;
    rdReq = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tickEn = 1'b1;
    @(posedge clk); #1;
    tickEn = 1'b0;
  endtask

  task automatic tickClr(input logic [31:0] d);
    @(posedge clk); #1;
    tickEn = 1'b1; regWrEn = 1'b1; regAddr = 8'h38; regWrData = d;
    @(posedge clk); #1;
    tickEn = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chkIrq(input logic e, input string t);
    @(negedge clk);
    nCmp++;
    if (irq !== e) begin
      nBad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic rdTime(input int s, input int m, input int h, input int d, input string t);
    rd(8'h00, 32'(s), t);
    rd(8'h04, 32'(m), t);
    rd(8'h08, 32'(h), t);
    rd(8'h0C, 32'(d), t);
  endtask

  initial begin
    #(20ns * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    idle(3); #1 rstN = 1'b1;
    // R1 reset state
    rdTime(0, 0, 0, 0, "R1");
    rd(8'h30, 32'h0, "R1");
    rd(8'h34, 32'h0, "R1");
    rd(8'h3C, 32'h0, "R1");
    rd(8'h5C, 32'h0096, "R1");
    chkIrq(1'b0, "R1");

    // R2 counting and holding
    repeat (3) tick();
    rd(8'h00, 32'd3, "R2");
    idle(10);
    rd(8'h00, 32'd3, "R2 hold");

    // R3 staging does not touch the counter; width masking (0x7F -> 0x3F)
    wr(8'h10, 32'h7F);
    rd(8'h10, 32'h3F, "R3 mask");
    wr(8'h10, 32'd57);
    rd(8'h10, 32'd57, "R3");
    rd(8'h00, 32'd3, "R3");
    // R4 early tick advances normally
    tick();
    rd(8'h00, 32'd4, "R4 early");
    rd(8'h34, 32'h0, "R4 early");
    // R4 commit
    idle(SETTLE);
    tick();
    rd(8'h00, 32'd57, "R4");
    rd(8'h34, 32'h100, "R4");
    tick(); tick();
    rd(8'h00, 32'd59, "R2");

    // R5 minutes load on the seconds rollover tick
    wr(8'h14, 32'd10);
    idle(SETTLE);
    tick();
    rd(8'h00, 32'd0, "R5");
    rd(8'h04, 32'd10, "R5 carry ignored");
    rd(8'h34, 32'h300, "R5");

    // R5 seconds load at 59 suppresses the carry into minutes
    for (int k = 0; k < 59; k++) tick();
    rd(8'h00, 32'd59, "R2");
    wr(8'h10, 32'd5);
    idle(SETTLE);
    tick();
    rd(8'h00, 32'd5, "R5");
    rd(8'h04, 32'd10, "R5 no carry out");

    // R7 clear by writing ones
    wr(8'h38, 32'h100);
    rd(8'h34, 32'h200, "R7");
    // R7 commit and clear in the same cycle
    wr(8'h10, 32'd20);
    idle(SETTLE);
    tickClr(32'h100);
    rd(8'h00, 32'd20, "R7");
    rd(8'h34, 32'h300, "R7 set wins");

    // R8 enable, mask and irq
    wr(8'h30, 32'hFFFF0200);
    rd(8'h30, 32'h0200, "R8");
    rd(8'h3C, 32'h0200, "R8");
    chkIrq(1'b1, "R8");
    wr(8'h38, 32'h300);
    rd(8'h34, 32'h0, "R8");
    rd(8'h3C, 32'h0, "R8");
    chkIrq(1'b0, "R8");

    // R6 rewrite restarts the wait
    wr(8'h18, 32'd7);
    idle(10);
    wr(8'h18, 32'd9);
    idle(12);
    tick();
    rd(8'h00, 32'd21, "R6");
    rd(8'h08, 32'd0, "R6 not yet");
    rd(8'h34, 32'h0, "R6");
    idle(SETTLE);
    tick();
    rd(8'h08, 32'd9, "R6");
    rd(8'h34, 32'h400, "R6");

    // R2 full wrap through days, all four fields loaded together
    wr(8'h10, 32'd59);
    wr(8'h14, 32'd59);
    wr(8'h18, 32'd23);
    wr(8'h1C, 32'hFFFF);
    idle(SETTLE);
    tick();
    rdTime(59, 59, 23, 65535, "R4 all");
    rd(8'h34, 32'hF00, "R4 all");
    tick();
    rdTime(0, 0, 0, 0, "R2 day wrap");

    // R9 power status
    rd(8'h5C, 32'h0096, "R9");
    wr(8'h58, 32'h00FF);
    rd(8'h5C, 32'h0000, "R9 clear");
    wr(8'h58, 32'h6900);
    rd(8'h5C, 32'h6900, "R9 valid");
    wr(8'h58, 32'h6901);
    rd(8'h5C, 32'h6900, "R9 low clear only");

    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule